// File: doc/BRIEF.md
# Set-Associative Branch Prediction Cache

This block remembers recently resolved branches so that a fetch stage can redirect early. Each cycle the fetch stage presents an address. If that address belongs to a remembered branch, the block returns a hit, a predicted direction and a stored target. Each entry holds a tag, a full target address and a 2-bit saturating counter. The counter tracks recent outcomes and selects the predicted direction.

Separately, the execute stage reports each resolved branch: its address, its actual direction and its actual target. The block updates the matching entry. If there is no matching entry and the branch was taken, the block allocates a new entry. The block also reports a cycle penalty for that branch. A correctly predicted taken branch costs nothing and a correctly predicted not-taken branch costs one cycle. A wrong or absent prediction costs two cycles if the branch was taken and three if it was not.

The default build holds 256 entries in 64 sets of 4 ways. A flush input invalidates every entry at once.

Top module: `branch_target_cache`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, no lookup hits. `flush` clears every valid bit and leaves the replacement pointers unchanged.
- R2: The set index is address bits [7:2] and the tag is bits [31:8]. `lk_hit` is high when a valid way of the indexed set holds that tag, and `lk_target` then equals the stored 32-bit target.
- R3: On a hit, `lk_taken` is high when the entry's counter is 2 or 3. On a miss, `lk_taken` is low.
- R4: A resolved taken branch that misses allocates an entry with counter 2 and the resolved target. A resolved not-taken branch that misses allocates nothing.
- R5: On a hit, a taken outcome increments the counter and saturates at 3. A not-taken outcome decrements it and saturates at 0. The entry stays valid at 0.
- R6: A taken outcome that hits overwrites the stored target with the resolved target.
- R7: `rs_penalty` is 0 for a taken branch that hit with a taken prediction and a matching target. It is 1 for a not-taken branch that hit with a not-taken prediction.
- R8: In every other case `rs_penalty` is 2 for a taken branch and 3 for a not-taken one. These cases are a miss, a wrong direction, or a taken branch with the wrong target.
- R9: Each set has a round-robin pointer that starts at way 0 after reset. Each allocation in the set uses the pointed way and advances the pointer by one, wrapping from way 3 to way 0.
- R10: Lookup and penalty reflect the state before that cycle's update. When `flush` and `rs_valid` are high together, the flush wins and the resolved branch changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_addr | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_target | output | 32 | Predicted target address |
| rs_valid | input | 1 | A resolved branch is reported this cycle |
| rs_addr | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Actual direction of the resolved branch |
| rs_target | input | 32 | Actual target of the resolved branch |
| rs_penalty | output | 2 | Cycle penalty of the resolved branch (0 to 3) |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 4 ways, 64 sets and 2-bit counters. Directed phases allocate five branches into one set to exercise the round-robin eviction. They walk a counter through both saturation points, and they collide a flush and a lookup with a same-cycle update. A long random phase confines addresses to four sets and six tags, with a small pool of targets. This keeps evictions, wrong-target mispredicts and aliasing-free tag matches frequent enough to cover every penalty value.

// File: rtl/branch_target_cache.sv
module branch_target_cache #(
  parameter int ADDR_W  = 32,
  parameter int WAYS    = 4,
  parameter int SETS    = 64,
  parameter int IDX_LSB = 2,
  parameter int CTR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_addr,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  output logic [1:0]        rs_penalty
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_LSB - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(1) << (CTR_W - 1);

  logic [TAG_W-1:0]  tag_q    [SETS][WAYS];
  logic [ADDR_W-1:0] target_q [SETS][WAYS];
  logic [CTR_W-1:0]  ctr_q    [SETS][WAYS];
  logic [WAYS-1:0]   valid_q  [SETS];
  logic [WAY_W-1:0]  rr_q     [SETS];

  logic [IDX_W-1:0] lk_idx, rs_idx;
  logic [TAG_W-1:0] lk_tag, rs_tag;
  logic [WAY_W-1:0] lk_way, rs_way, rs_victim;
  logic             rs_hit, rs_pred, rs_good;
  logic [CTR_W-1:0] rs_ctr;

  assign lk_idx = lk_addr[IDX_LSB +: IDX_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];
  assign rs_idx = rs_addr[IDX_LSB +: IDX_W];
  assign rs_tag = rs_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    lk_hit = 1'b0;
    lk_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (valid_q[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
        lk_hit = 1'b1;
        lk_way = WAY_W'(w);
      end
  end

  always_comb begin
    rs_hit = 1'b0;
    rs_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (valid_q[rs_idx][w] && tag_q[rs_idx][w] == rs_tag) begin
        rs_hit = 1'b1;
        rs_way = WAY_W'(w);
      end
  end

  assign lk_target = target_q[lk_idx][lk_way];
  assign lk_taken  = lk_hit && ctr_q[lk_idx][lk_way][CTR_W-1];

  assign rs_ctr     = ctr_q[rs_idx][rs_way];
  assign rs_pred    = rs_hit && rs_ctr[CTR_W-1];
  assign rs_good    = rs_hit && (rs_pred == rs_taken) &&
                      (!rs_taken || target_q[rs_idx][rs_way] == rs_target);
  assign rs_penalty = {!rs_good, !rs_taken};
  assign rs_victim  = rr_q[rs_idx];

  always_ff @(posedge clk) begin
    if (rs_valid && !flush) begin
      if (rs_hit) begin
        if (rs_taken) begin
          target_q[rs_idx][rs_way] <= rs_target;
          if (rs_ctr != CTR_MAX) ctr_q[rs_idx][rs_way] <= rs_ctr + 1'b1;
        end else if (rs_ctr != '0) begin
          ctr_q[rs_idx][rs_way] <= rs_ctr - 1'b1;
        end
      end else if (rs_taken) begin
        tag_q[rs_idx][rs_victim]    <= rs_tag;
        target_q[rs_idx][rs_victim] <= rs_target;
        ctr_q[rs_idx][rs_victim]    <= CTR_INIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (rs_valid && !rs_hit && rs_taken) begin
      valid_q[rs_idx][rs_victim] <= 1'b1;
      rr_q[rs_idx] <= (rs_victim == WAY_W'(WAYS - 1)) ? '0 : rs_victim + 1'b1;
    end
  end
endmodule

// File: rtl/btc_checker.sv
module btc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              lk_hit,
  input logic              lk_taken,
  input logic [ADDR_W-1:0] lk_target,
  input logic              rs_valid,
  input logic [ADDR_W-1:0] rs_addr,
  input logic              rs_taken,
  input logic [ADDR_W-1:0] rs_target,
  input logic [1:0]        rs_penalty
);
  a_r1_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  a_r4_taken_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_taken && !flush) |=>
      (lk_addr != $past(rs_addr)) || (lk_hit && lk_target == $past(rs_target)));

  a_r5_weak_stays_weak: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_taken && !flush && lk_addr == rs_addr && !lk_taken) |=>
      (lk_addr != $past(rs_addr)) || !lk_taken);

  a_r7_correct_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_addr == lk_addr && lk_hit && lk_taken == rs_taken &&
     (!rs_taken || lk_target == rs_target)) |-> rs_penalty == {1'b0, !rs_taken});

  a_r8_miss_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_addr == lk_addr && !lk_hit) |-> rs_penalty[1]);
endmodule

bind branch_target_cache btc_checker #(.ADDR_W(ADDR_W)) i_btc_checker (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lk_addr(lk_addr),
  .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
  .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
  .rs_target(rs_target), .rs_penalty(rs_penalty)
);

// File: tb/test_branch_target_cache.sv
`timescale 1ns/1ps
module test_branch_target_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_addr = '0;
  logic        rs_taken = 1'b0;
  logic [31:0] rs_target = '0;
  logic [1:0]  rs_penalty;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_val [64][4];
  logic [23:0] m_tag [64][4];
  logic [31:0] m_tgt [64][4];
  int          m_ctr [64][4];
  int          m_rr  [64];

  always #2.5 clk = ~clk;

  branch_target_cache i_branch_target_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
    .rs_target(rs_target), .rs_penalty(rs_penalty)
  );

  function automatic logic [31:0] mk(input int set, input int tag);
    return {tag[23:0], set[5:0], 2'b00};
  endfunction

  function automatic int find(input logic [31:0] a);
    for (int w = 0; w < 4; w++)
      if (m_val[a[7:2]][w] && m_tag[a[7:2]][w] == a[31:8]) return w;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] la, input bit rv, input logic [31:0] ra,
                      input bit rt, input logic [31:0] rtg, input bit fl,
                      input string req);
    int w, s, ep, lw;
    bit good;
    lk_addr = la; rs_valid = rv; rs_addr = ra; rs_taken = rt;
    rs_target = rtg; flush = fl;
    #1;
    lw = find(la);
    check(lk_hit == (lw >= 0), req, "lk_hit", lk_hit, lw >= 0);
    if (lw >= 0) begin
      check(lk_target == m_tgt[la[7:2]][lw], req, "lk_target",
            lk_target, m_tgt[la[7:2]][lw]);
      check(lk_taken == (m_ctr[la[7:2]][lw] >= 2), req, "lk_taken",
            lk_taken, m_ctr[la[7:2]][lw] >= 2);
    end else begin
      check(lk_taken == 1'b0, "R3", "lk_taken on miss", lk_taken, 0);
    end
    if (rv) begin
      s = ra[7:2];
      w = find(ra);
      good = (w >= 0) && ((m_ctr[s][w] >= 2) == rt) && (!rt || m_tgt[s][w] == rtg);
      ep = (good ? 0 : 2) + (rt ? 0 : 1);
      check(rs_penalty == ep, ep < 2 ? "R7" : "R8", "rs_penalty", rs_penalty, ep);
      if (!fl) begin
        if (w >= 0) begin
          if (rt) begin
            m_tgt[s][w] = rtg;
            if (m_ctr[s][w] < 3) m_ctr[s][w]++;
          end else if (m_ctr[s][w] > 0) m_ctr[s][w]--;
        end else if (rt) begin
          w = m_rr[s];
          m_val[s][w] = 1; m_tag[s][w] = ra[31:8];
          m_tgt[s][w] = rtg; m_ctr[s][w] = 2;
          m_rr[s] = (w + 1) % 4;
        end
      end
    end
    if (fl)
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 4; j++) m_val[i][j] = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] la, input string req);
    step(la, 0, '0, 0, '0, 0, req);
  endtask

  task automatic resolve(input logic [31:0] la, input logic [31:0] ra, input bit rt,
                         input logic [31:0] rtg, input string req);
    step(la, 1, ra, rt, rtg, 0, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_rr[i] = 0;
      for (int j = 0; j < 4; j++) begin
        m_val[i][j] = 0; m_ctr[i][j] = 0; m_tag[i][j] = '0; m_tgt[i][j] = '0;
      end
    end
    repeat (3) @(negedge clk);
    #1;
    check(lk_hit == 1'b0, "R1", "lk_hit in reset", lk_hit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    look(mk(5, 1), "R1");

    resolve(mk(5, 1), mk(5, 1), 0, 32'h100, "R4");
    look(mk(5, 1), "R4");
    resolve(mk(5, 1), mk(5, 1), 1, 32'h1000, "R4");
    look(mk(5, 1), "R4");
    check(lk_hit && lk_target == 32'h1000, "R4", "allocated target", lk_target, 32'h1000);

    resolve(mk(5, 1), mk(5, 1), 1, 32'h2000, "R10");
    look(mk(5, 1), "R6");
    check(lk_target == 32'h2000, "R6", "target rewritten", lk_target, 32'h2000);

    repeat (3) resolve(mk(5, 1), mk(5, 1), 1, 32'h2000, "R5");
    repeat (4) resolve(mk(5, 1), mk(5, 1), 0, 32'h0, "R5");
    look(mk(5, 1), "R5");
    check(lk_hit && !lk_taken, "R5", "counter at floor", lk_taken, 0);
    resolve(mk(5, 1), mk(5, 1), 0, 32'h0, "R7");
    look(mk(5, 1), "R5");

    for (int t = 1; t <= 5; t++) resolve(mk(9, t), mk(9, t), 1, 32'h9000 + t, "R9");
    look(mk(9, 1), "R9");
    check(!lk_hit, "R9", "oldest way evicted", lk_hit, 0);
    for (int t = 2; t <= 5; t++) look(mk(9, t), "R9");

    step(mk(12, 7), 1, mk(12, 7), 1, 32'hC000, 1, "R10");
    look(mk(12, 7), "R10");
    check(!lk_hit, "R10", "flush beats update", lk_hit, 0);
    look(mk(9, 2), "R1");
    resolve(mk(9, 2), mk(9, 6), 1, 32'h9600, "R9");
    look(mk(9, 6), "R9");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] la, ra, tg;
      la = mk($urandom_range(0, 3), $urandom_range(0, 5));
      ra = ($urandom_range(0, 2) == 0) ? la : mk($urandom_range(0, 3), $urandom_range(0, 5));
      tg = 32'h4000 + 32'($urandom_range(0, 2)) * 32'h40;
      step(la, $urandom_range(0, 3) != 0, ra, $urandom_range(0, 1) == 1, tg,
           $urandom_range(0, 199) == 0, "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule